// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a boot-block flash device. A host writes 8-bit command bytes on `data_i` with a one-cycle write strobe. The controller decodes them into read-mode changes, status clearing, program and erase requests, and erase suspend and resume. A down-counter stands in for the internal write engine: it keeps the device busy for a parameterised number of cycles and then reports completion.

The controller holds the status byte and sets the error flags. It also drives a read multiplexer. That multiplexer returns array data, an identifier byte or the status byte, depending on the last accepted read-mode command. While an operation runs, most commands are refused. A program operation accepts only status reads. An erase operation accepts only status reads and suspend.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset (`rst_ni` low) the block is in read-array mode, is not busy, and all error bits are zero. A status read then returns 80h.
- R2: In read-array mode `rd_data_o` follows `array_data_i`. A read mode persists until another accepted command changes it. Command FFh selects read-array mode.
- R3: Command 90h selects identifier mode. With `addr0_i` low the read returns 89h. With `addr0_i` high it returns 78h when `TOP_BOOT`=1 and 79h otherwise.
- R4: Program starts with 40h or 10h, and the next write is taken as the data byte. The block then reads status and stays busy for exactly `PROG_CYCLES` cycles. While busy, status bit 7 is 0; it returns to 1 when the operation ends.
- R5: While programming, every write other than 70h has no effect. That includes a new setup code and a read-mode change.
- R6: Erase starts with 20h followed by D0h. It stays busy for exactly `ERASE_CYCLES` cycles. While erasing, only 70h and B0h are accepted.
- R7: An erase setup followed by any byte other than D0h sets status bits 4 and 5. No operation starts.
- R8: When `vpp_ok_i` is low at the data or confirm write, status bit 3 is set and nothing starts. Status bits 3 to 5 are set only by internal logic.
- R9: Command 50h, accepted only when idle, clears status bits 3, 4 and 5 and selects read-array mode.
- R10: B0h during an erase suspends it. Status bits 7 and 6 read 1 and the remaining count is frozen. D0h resumes the erase, clears bit 6 and makes bit 7 read 0. The busy cycles before and after the suspend add up to `ERASE_CYCLES`.
- R11: While suspended, only FFh, 90h, 70h and D0h are accepted. Other codes, including program setup, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe, one cycle per byte |
| data_i | input | 8 | Command or program data byte |
| addr0_i | input | 1 | Address bit 0, selects the identifier byte |
| vpp_ok_i | input | 1 | Programming supply is in range |
| array_data_i | input | 8 | Array contents for the addressed location |
| rd_data_o | output | 8 | Read data: array, identifier or status |
| busy_o | output | 1 | Program or erase in progress and not suspended |

## Verification
The hardest state to reach is a suspended erase with a partly used count. Checking it needs the busy cycles on both sides of the suspend, and the suspend must land strictly inside the erase window. The stimulus issues B0h a known number of cycles after the confirm. It then holds the suspend for a while and issues foreign commands that must be ignored, including a program setup. After the resume, it counts busy cycles until done, so a wrong freeze or a restart from the full count shows up as a total that differs from `ERASE_CYCLES`.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_ID     = 2'd1,
    RD_STATUS = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE        = 3'd0,
    PH_PROG_SETUP  = 3'd1,
    PH_ERASE_SETUP = 3'd2,
    PH_PROG        = 3'd3,
    PH_ERASE       = 3'd4,
    PH_SUSP        = 3'd5
  } phase_e;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_ID     = 8'h90;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR       = 8'h50;
  localparam logic [7:0] CMD_PROG_A      = 8'h40;
  localparam logic [7:0] CMD_PROG_B      = 8'h10;
  localparam logic [7:0] CMD_ERASE       = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

  localparam logic [7:0] MFR_CODE        = 8'h89;
  localparam logic [7:0] DEV_CODE_TOP    = 8'h78;
  localparam logic [7:0] DEV_CODE_BOTTOM = 8'h79;

endpackage

// File: rtl/wsm_timer.sv
module wsm_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import flash_cmd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  logic [7:0] data_i,
  input  logic     vpp_ok_i,
  input  logic     wsm_zero_i,
  output rd_mode_e mode_o,
  output phase_e   phase_o,
  output logic     load_o,
  output logic     load_erase_o,
  output logic     set_vpp_o,
  output logic     set_prog_o,
  output logic     set_erase_o,
  output logic     clr_o
);

  rd_mode_e mode_q, mode_d;
  phase_e   phase_q, phase_d;
  logic     done;

  assign done = (phase_q == PH_PROG || phase_q == PH_ERASE) && wsm_zero_i;

  always_comb begin
    mode_d       = mode_q;
    phase_d      = phase_q;
    load_o       = 1'b0;
    load_erase_o = 1'b0;
    set_vpp_o    = 1'b0;
    set_prog_o   = 1'b0;
    set_erase_o  = 1'b0;
    clr_o        = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (we_i) begin
          case (data_i)
            CMD_READ_ARRAY:  mode_d = RD_ARRAY;
            CMD_READ_ID:     mode_d = RD_ID;
            CMD_READ_STATUS: mode_d = RD_STATUS;
            CMD_CLEAR: begin
              clr_o  = 1'b1;
              mode_d = RD_ARRAY;
            end
            CMD_PROG_A, CMD_PROG_B: begin
              phase_d = PH_PROG_SETUP;
              mode_d  = RD_STATUS;
            end
            CMD_ERASE: begin
              phase_d = PH_ERASE_SETUP;
              mode_d  = RD_STATUS;
            end
            default: ;
          endcase
        end
      end
      PH_PROG_SETUP: begin
        if (we_i) begin
          if (vpp_ok_i) begin
            phase_d = PH_PROG;
            load_o  = 1'b1;
          end else begin
            set_vpp_o = 1'b1;
            phase_d   = PH_IDLE;
          end
        end
      end
      PH_ERASE_SETUP: begin
        if (we_i) begin
          if (data_i != CMD_CONFIRM) begin
            set_prog_o  = 1'b1;
            set_erase_o = 1'b1;
            phase_d     = PH_IDLE;
          end else if (vpp_ok_i) begin
            phase_d      = PH_ERASE;
            load_o       = 1'b1;
            load_erase_o = 1'b1;
          end else begin
            set_vpp_o = 1'b1;
            phase_d   = PH_IDLE;
          end
        end
      end
      PH_PROG: begin
        if (we_i && data_i == CMD_READ_STATUS) mode_d = RD_STATUS;
        if (done) phase_d = PH_IDLE;
      end
      PH_ERASE: begin
        if (we_i && data_i == CMD_READ_STATUS) mode_d = RD_STATUS;
        if (done) begin
          phase_d = PH_IDLE;
        end else if (we_i && data_i == CMD_SUSPEND) begin
          phase_d = PH_SUSP;
          mode_d  = RD_STATUS;
        end
      end
      PH_SUSP: begin
        if (we_i) begin
          case (data_i)
            CMD_READ_ARRAY:  mode_d = RD_ARRAY;
            CMD_READ_ID:     mode_d = RD_ID;
            CMD_READ_STATUS: mode_d = RD_STATUS;
            CMD_CONFIRM:     phase_d = PH_ERASE;
            default: ;
          endcase
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= RD_ARRAY;
      phase_q <= PH_IDLE;
    end else begin
      mode_q  <= mode_d;
      phase_q <= phase_d;
    end
  end

  assign mode_o  = mode_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/status_reg.sv
module status_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_vpp_i,
  input  logic       set_prog_i,
  input  logic       set_erase_i,
  input  logic       clr_i,
  input  logic       busy_i,
  input  logic       susp_i,
  output logic [7:0] sr_o
);

  logic [2:0] err_q;  // {erase, program, supply}

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
    end else if (clr_i) begin
      err_q <= '0;
    end else begin
      err_q <= err_q | {set_erase_i, set_prog_i, set_vpp_i};
    end
  end

  assign sr_o = {~busy_i, susp_i, err_q, 3'b000};

endmodule

// File: rtl/rd_mux.sv
module rd_mux
  import flash_cmd_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1
) (
  input  rd_mode_e   mode_i,
  input  logic       addr0_i,
  input  logic [7:0] array_data_i,
  input  logic [7:0] sr_i,
  output logic [7:0] rd_data_o
);

  logic [7:0] dev_code;

  generate
    if (TOP_BOOT) begin : g_top
      assign dev_code = DEV_CODE_TOP;
    end else begin : g_bottom
      assign dev_code = DEV_CODE_BOTTOM;
    end
  endgenerate

  always_comb begin
    case (mode_i)
      RD_ID:     rd_data_o = addr0_i ? dev_code : MFR_CODE;
      RD_STATUS: rd_data_o = sr_i;
      default:   rd_data_o = array_data_i;
    endcase
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 24,
  parameter bit TOP_BOOT     = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] data_i,
  input  logic       addr0_i,
  input  logic       vpp_ok_i,
  input  logic [7:0] array_data_i,
  output logic [7:0] rd_data_o,
  output logic       busy_o
);

  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYCLES - 1);

  rd_mode_e         mode;
  phase_e           phase;
  logic             load, load_erase;
  logic             set_vpp, set_prog, set_erase, clr;
  logic             wsm_zero;
  logic [CNT_W-1:0] wsm_cnt;
  logic [7:0]       sr;
  logic             busy, susp;

  cmd_decoder u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .data_i      (data_i),
    .vpp_ok_i    (vpp_ok_i),
    .wsm_zero_i  (wsm_zero),
    .mode_o      (mode),
    .phase_o     (phase),
    .load_o      (load),
    .load_erase_o(load_erase),
    .set_vpp_o   (set_vpp),
    .set_prog_o  (set_prog),
    .set_erase_o (set_erase),
    .clr_o       (clr)
  );

  assign busy = (phase == PH_PROG) || (phase == PH_ERASE);
  assign susp = (phase == PH_SUSP);

  wsm_timer #(.CNT_W(CNT_W)) u_wsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_erase ? ERASE_LD : PROG_LD),
    .run_i     (busy),
    .zero_o    (wsm_zero),
    .cnt_o     (wsm_cnt)
  );

  status_reg u_sr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_vpp_i  (set_vpp),
    .set_prog_i (set_prog),
    .set_erase_i(set_erase),
    .clr_i      (clr),
    .busy_i     (busy),
    .susp_i     (susp),
    .sr_o       (sr)
  );

  rd_mux #(.TOP_BOOT(TOP_BOOT)) u_mux (
    .mode_i      (mode),
    .addr0_i     (addr0_i),
    .array_data_i(array_data_i),
    .sr_i        (sr),
    .rd_data_o   (rd_data_o)
  );

  assign busy_o = busy;

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [7:0]       data_i,
  input logic             addr0_i,
  input logic             vpp_ok_i,
  input logic [7:0]       rd_data_o,
  input logic             busy_o,
  input phase_e           phase_i,
  input rd_mode_e         mode_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [2:0]       err_i
);

  logic clr_cmd;
  assign clr_cmd = we_i && data_i == CMD_CLEAR && phase_i == PH_IDLE;

  AST_CLEAR_TO_ARRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> (mode_i == RD_ARRAY && err_i == 3'b000)); // R9

  AST_PROG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_PROG && we_i && data_i != CMD_READ_STATUS) |=> $stable(mode_i)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_cmd) |=> ((err_i & $past(err_i)) == $past(err_i))); // R8

  AST_SUSP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_SUSP) |=> $stable(cnt_i)); // R10

  AST_START_NEEDS_VPP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && $past(phase_i) != PH_SUSP) |-> $past(vpp_ok_i)); // R8

  AST_ID_MFR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == RD_ID && !addr0_i) |-> rd_data_o == MFR_CODE); // R3

  AST_BUSY_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_i == RD_STATUS) |-> !rd_data_o[7]); // R4

endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .data_i   (data_i),
  .addr0_i  (addr0_i),
  .vpp_ok_i (vpp_ok_i),
  .rd_data_o(rd_data_o),
  .busy_o   (busy_o),
  .phase_i  (phase),
  .mode_i   (mode),
  .cnt_i    (wsm_cnt),
  .err_i    (sr[5:3])
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

  localparam int PROG_CYCLES  = 8;
  localparam int ERASE_CYCLES = 24;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       addr0_i = 1'b0;
  logic       vpp_ok_i = 1'b1;
  logic [7:0] array_data_i = 8'h5A;
  logic [7:0] rd_data_o;
  logic       busy_o;

  int vectors = 0;
  int miscompares = 0;
  bit done_flag = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  flash_cmd_ctrl #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .TOP_BOOT    (1'b1)
  ) i_flash_cmd_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .data_i      (data_i),
    .addr0_i     (addr0_i),
    .vpp_ok_i    (vpp_ok_i),
    .array_data_i(array_data_i),
    .rd_data_o   (rd_data_o),
    .busy_o      (busy_o)
  );

  task automatic check(input int got, input int exp, input string req);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // one write, entered and left at a falling edge
  task automatic wr(input logic [7:0] d);
    we_i = 1'b1;
    data_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
    data_i = 8'h00;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    check(rd_data_o, 8'h5A, "R1 array after reset");
    check(busy_o, 0, "R1 idle after reset");
    wr(8'h70);
    check(rd_data_o, 8'h80, "R1 status after reset");
  endtask

  task automatic t_array();
    wr(8'hFF);
    array_data_i = 8'hC3;
    #1;
    check(rd_data_o, 8'hC3, "R2 array follows input");
    repeat (5) @(negedge clk_i);
    array_data_i = 8'h3C;
    #1;
    check(rd_data_o, 8'h3C, "R2 mode persists");
    array_data_i = 8'h5A;
  endtask

  task automatic t_ident();
    wr(8'h90);
    addr0_i = 1'b0;
    #1;
    check(rd_data_o, 8'h89, "R3 manufacturer code");
    addr0_i = 1'b1;
    #1;
    check(rd_data_o, 8'h78, "R3 device code top boot");
    addr0_i = 1'b0;
  endtask

  task automatic t_program();
    int n;
    wr(8'h10);
    wr(8'h55);
    check(rd_data_o, 8'h00, "R4 status busy");
    wait_ready(n);
    check(n, PROG_CYCLES, "R4 program duration");
    check(rd_data_o, 8'h80, "R4 status ready");
    wr(8'h40);
    wr(8'h66);
    wr(8'hFF);
    check(rd_data_o, 8'h00, "R5 read array ignored while programming");
    wr(8'h90);
    wait_ready(n);
    check(rd_data_o, 8'h80, "R5 still status mode after program");
  endtask

  task automatic t_erase();
    int n;
    wr(8'h20);
    wr(8'hD0);
    wait_ready(n);
    check(n, ERASE_CYCLES, "R6 erase duration");
    wr(8'h20);
    wr(8'hD0);
    wr(8'hFF);
    wr(8'h40);
    check(rd_data_o, 8'h00, "R6 foreign commands ignored while erasing");
    wait_ready(n);
    check(rd_data_o, 8'h80, "R6 ready after erase");
    wr(8'h90);
    check(busy_o, 0, "R6 program setup was not latched");
    check(rd_data_o, 8'h89, "R6 identifier accepted after erase");
  endtask

  task automatic t_abort();
    wr(8'h20);
    wr(8'hFF);
    check(busy_o, 0, "R7 no erase after bad confirm");
    check(rd_data_o, 8'hB0, "R7 bits 5 and 4 set");
    wr(8'h50);
    check(rd_data_o, 8'h5A, "R9 clear returns to array");
    wr(8'h70);
    check(rd_data_o, 8'h80, "R9 error bits cleared");
  endtask

  task automatic t_vpp();
    vpp_ok_i = 1'b0;
    wr(8'h40);
    wr(8'h12);
    check(busy_o, 0, "R8 program blocked by supply");
    check(rd_data_o, 8'h88, "R8 supply error bit");
    wr(8'h50);
    wr(8'h20);
    wr(8'hD0);
    check(busy_o, 0, "R8 erase blocked by supply");
    check(rd_data_o, 8'h88, "R8 supply error on erase");
    vpp_ok_i = 1'b1;
    wr(8'h50);
    wr(8'h70);
    check(rd_data_o, 8'h80, "R9 clear after supply error");
  endtask

  task automatic t_suspend();
    int n;
    int total;
    total = 0;
    wr(8'h20);
    wr(8'hD0);
    repeat (5) begin
      if (busy_o) total++;
      @(negedge clk_i);
    end
    total++;  // cycle consumed by the suspend write
    wr(8'hB0);
    check(busy_o, 0, "R10 not busy when suspended");
    check(rd_data_o, 8'hC0, "R10 status bits 7 and 6");
    repeat (10) @(negedge clk_i);
    check(rd_data_o, 8'hC0, "R10 suspend holds");
    wr(8'hFF);
    check(rd_data_o, 8'h5A, "R11 read array while suspended");
    wr(8'h40);
    check(rd_data_o, 8'h5A, "R11 program setup ignored while suspended");
    wr(8'h70);
    check(rd_data_o, 8'hC0, "R11 status while suspended");
    wr(8'hD0);
    check(rd_data_o, 8'h00, "R10 resume clears bits 7 and 6");
    wait_ready(n);
    check(total + n, ERASE_CYCLES, "R10 erase resumes from frozen count");
    check(rd_data_o, 8'h80, "R10 ready after resumed erase");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_array();
    t_ident();
    t_program();
    t_erase();
    t_abort();
    t_vpp();
    t_suspend();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done_flag) begin
      done_flag = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule